// File: doc/BRIEF.md
# Two-Entry Receive Holding Buffer with Overrun Lock

This block sits between a serial receive shifter and a register-read path. Each completed character is up to nine bits wide and arrives on a valid/ready stream. The block holds up to two of them in arrival order. The oldest unread character is presented as a low byte plus a separate upper field, which is the ninth bit at the default widths. A read strobe on the low byte removes that character. A receive flag stays high while anything is unread.

The serial source cannot pause in the middle of a character, so a full buffer does not pull `in_ready` low. Instead, a character offered while both entries are occupied and no read is happening is an overrun. That character is dropped, the stored pair is kept intact, and the error flag is raised. While the error flag is high, `in_ready` stays low and every offered character is discarded. These are the only back-pressure rules: `in_ready` is low while the port is disabled or an overrun is pending, and a transfer happens only on a cycle where `in_valid` and `in_ready` are both high.

How the error clears depends on the mode when the overrun happened. In single-shot mode, a read of the low byte clears it. In continuous mode, it clears only when the continuous enable is dropped or the port is disabled. Disabling the port empties the buffer and clears both flags.

Top module: `rxb_top`

## Requirements
- R1: After reset, `rx_flag` and `ovr_err` are 0, and `in_ready` equals `port_en`.
- R2: An accepted character appears at the outputs on the clock edge that accepts it, and characters leave in arrival order.
- R3: `dout_lo` carries bits [7:0] and `dout_hi` carries bit [8] of the oldest unread character. Both stay stable until that character is read, so the upper field can be read before the low byte.
- R4: A `rd_lo_stb` pulse removes the oldest character. A pulse while the buffer is empty changes nothing.
- R5: The buffer holds two characters. A third one offered while full with no read in the same cycle sets `ovr_err` on that edge and leaves the stored pair unchanged.
- R6: While `ovr_err` is 1, `in_ready` is 0 and offered characters are dropped without being stored.
- R7: An overrun that occurs with `cont_en` = 0 is cleared by a `rd_lo_stb` pulse, which also removes the oldest character.
- R8: An overrun that occurs with `cont_en` = 1 survives reads and clears on the edge after `cont_en` is sampled 0.
- R9: When the buffer is full, a read and an offered character in the same cycle act as a pop followed by a push, with no overrun.
- R10: `port_en` = 0 empties the buffer, clears `ovr_err`, and holds `in_ready` at 0.
- R11: `rx_flag` is 1 whenever at least one unread character is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low flushes the buffer and clears the flags |
| cont_en | input | 1 | Continuous receive mode enable |
| in_valid | input | 1 | Completed character offered |
| in_ready | output | 1 | Character can be taken |
| in_data | input | 9 | Offered character |
| rd_lo_stb | input | 1 | Read of the low byte; pops the oldest character |
| dout_lo | output | 8 | Low byte of the oldest character |
| dout_hi | output | 1 | Upper field (ninth bit) of the oldest character |
| rx_flag | output | 1 | Unread data present |
| ovr_err | output | 1 | Overrun error, locks reception |

## Verification
Every result is registered, so it is due on the first rising edge after the stimulus cycle. The bench drives inputs on falling edges and samples on the following falling edge, which puts each sample one edge after its stimulus. The continuous-mode clearing is checked in two steps: once while `cont_en` is still high and several reads have been made, and again one edge after `cont_en` falls. A dropped character is shown to be absent by draining the buffer afterwards and checking that `rx_flag` falls exactly when the stored count says it should.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_CONT   = 2'd2
  } err_state_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] slot [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push && !flush && wr_ptr == PTR_W'(i))
        slot[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = slot[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rxb_gate.sv
module rxb_gate (
  input  logic port_en,
  input  logic err,
  input  logic in_valid,
  input  logic rd_lo_stb,
  input  logic full,
  input  logic empty,
  output logic in_ready,
  output logic push,
  output logic pop,
  output logic ovr_evt
);
  logic take;

  always_comb begin
    in_ready = port_en && !err;
    take     = in_valid && in_ready;
    pop      = port_en && rd_lo_stb && !empty;
    push     = take && (!full || pop);
    ovr_evt  = take && full && !pop;
  end
endmodule

// File: rtl/rxb_errctl.sv
module rxb_errctl
  import rxb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic cont_en,
  input  logic ovr_evt,
  input  logic rd_lo_stb,
  output logic err,
  output logic err_cont
);
  err_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (!port_en) begin
      st_nx = ERR_NONE;
    end else begin
      unique case (st)
        ERR_NONE:   if (ovr_evt) st_nx = cont_en ? ERR_CONT : ERR_SINGLE;
        ERR_SINGLE: if (rd_lo_stb) st_nx = ERR_NONE;
        ERR_CONT:   if (!cont_en) st_nx = ERR_NONE;
        default:    st_nx = ERR_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ERR_NONE;
    else        st <= st_nx;
  end

  assign err      = (st != ERR_NONE);
  assign err_cont = (st == ERR_CONT);
endmodule

// File: rtl/rxb_top.sv
module rxb_top #(
  parameter int DATA_W = 9,
  parameter int LO_W   = 8,
  parameter int DEPTH  = 2,
  localparam int HI_W  = DATA_W - LO_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              cont_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_lo_stb,
  output logic [LO_W-1:0]   dout_lo,
  output logic [HI_W-1:0]   dout_hi,
  output logic              rx_flag,
  output logic              ovr_err
);
  logic              push, pop, ovr_evt, full, empty, err_cont;
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  count;

  rxb_gate u_gate (
    .port_en   (port_en),
    .err       (ovr_err),
    .in_valid  (in_valid),
    .rd_lo_stb (rd_lo_stb),
    .full      (full),
    .empty     (empty),
    .in_ready  (in_ready),
    .push      (push),
    .pop       (pop),
    .ovr_evt   (ovr_evt)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!port_en),
    .push  (push),
    .pop   (pop),
    .wdata (in_data),
    .head  (head),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  rxb_errctl u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .cont_en   (cont_en),
    .ovr_evt   (ovr_evt),
    .rd_lo_stb (rd_lo_stb),
    .err       (ovr_err),
    .err_cont  (err_cont)
  );

  assign dout_lo = head[LO_W-1:0];
  assign dout_hi = head[DATA_W-1:LO_W];
  assign rx_flag = !empty;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DATA_W = 9,
  parameter int LO_W   = 8,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 port_en,
  input logic                 cont_en,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 rd_lo_stb,
  input logic [LO_W-1:0]      dout_lo,
  input logic [DATA_W-LO_W-1:0] dout_hi,
  input logic                 rx_flag,
  input logic                 ovr_err,
  input logic [CNT_W-1:0]     count,
  input logic                 err_cont
);
  logic is_full;
  assign is_full = (count == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && is_full && in_valid && in_ready && !rd_lo_stb) |=> (ovr_err && count == CNT_W'(DEPTH))); // R5
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && port_en && !rd_lo_stb) |=> $stable(count)); // R6
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && port_en && !rd_lo_stb) |=> ($stable(dout_lo) && $stable(dout_hi))); // R3
  AST_CONT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && err_cont && cont_en && port_en) |=> ovr_err); // R8
  AST_SIMUL_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !ovr_err && is_full && in_valid && rd_lo_stb) |=> (!ovr_err && count == CNT_W'(DEPTH))); // R9
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!rx_flag && !ovr_err)); // R10
endmodule

bind rxb_top rxb_checker #(
  .DATA_W(DATA_W), .LO_W(LO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_en   (port_en),
  .cont_en   (cont_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rd_lo_stb (rd_lo_stb),
  .dout_lo   (dout_lo),
  .dout_hi   (dout_hi),
  .rx_flag   (rx_flag),
  .ovr_err   (ovr_err),
  .count     (count),
  .err_cont  (err_cont)
);

// File: tb/rxb_top_tb.sv
module rxb_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b1;
  logic       cont_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       rd_lo_stb = 1'b0;
  logic [7:0] dout_lo;
  logic [0:0] dout_hi;
  logic       rx_flag;
  logic       ovr_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rxb_top u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_lo_stb(rd_lo_stb), .dout_lo(dout_lo), .dout_hi(dout_hi),
    .rx_flag(rx_flag), .ovr_err(ovr_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle: inputs set at a falling edge, sampled at the next falling edge
  task automatic step(input logic v, input logic [8:0] d, input logic rd);
    in_valid  = v;
    in_data   = d;
    rd_lo_stb = rd;
    @(negedge clk);
    in_valid  = 1'b0;
    rd_lo_stb = 1'b0;
  endtask

  task automatic push(input logic [8:0] d); step(1'b1, d, 1'b0); endtask
  task automatic rd();                      step(1'b0, 9'h0, 1'b1); endtask

  task automatic t_reset();
    check("R1 rx_flag", rx_flag, 0);
    check("R1 ovr_err", ovr_err, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_basic();
    push(9'h1A5);
    check("R2 flag after push", rx_flag, 1);
    check("R3 low byte", dout_lo, 8'hA5);
    check("R3 ninth bit", dout_hi, 1);
    push(9'h03C);
    check("R3 head kept after second push", dout_lo, 8'hA5);
    rd();
    check("R11 flag with one left", rx_flag, 1);
    check("R2 order low", dout_lo, 8'h3C);
    check("R3 ninth bit second", dout_hi, 0);
    rd();
    check("R4 empty after reads", rx_flag, 0);
    rd();
    check("R4 read on empty", rx_flag, 0);
    push(9'h055);
    check("R4 empty read harmless", dout_lo, 8'h55);
    rd();
    check("R4 drained", rx_flag, 0);
  endtask

  task automatic t_single_ovr();
    cont_en = 1'b0;
    push(9'h011); push(9'h122);
    check("R5 no error at two", ovr_err, 0);
    push(9'h033);
    check("R5 overrun flagged", ovr_err, 1);
    check("R5 head unchanged", dout_lo, 8'h11);
    check("R6 ready low", in_ready, 0);
    push(9'h044);
    check("R6 still locked", ovr_err, 1);
    rd();
    check("R7 cleared by read", ovr_err, 0);
    check("R7 second entry", dout_lo, 8'h22);
    check("R7 second ninth", dout_hi, 1);
    rd();
    check("R6 dropped chars absent", rx_flag, 0);
  endtask

  task automatic t_cont_ovr();
    cont_en = 1'b1;
    push(9'h0A1); push(9'h0A2); push(9'h0A3);
    check("R8 overrun flagged", ovr_err, 1);
    rd();
    check("R8 read keeps error", ovr_err, 1);
    check("R8 read pops", dout_lo, 8'hA2);
    rd();
    check("R8 empty yet error", ovr_err, 1);
    check("R8 empty flag", rx_flag, 0);
    cont_en = 1'b0;
    @(negedge clk);
    check("R8 cleared by cont_en low", ovr_err, 0);
    check("R8 ready again", in_ready, 1);
  endtask

  task automatic t_simul();
    cont_en = 1'b0;
    push(9'h061); push(9'h062);
    step(1'b1, 9'h163, 1'b1);
    check("R9 no overrun", ovr_err, 0);
    check("R9 popped first", dout_lo, 8'h62);
    rd();
    check("R9 pushed value", dout_lo, 8'h63);
    check("R9 pushed ninth", dout_hi, 1);
    rd();
    check("R9 drained", rx_flag, 0);
  endtask

  task automatic t_flush();
    cont_en = 1'b1;
    push(9'h071); push(9'h072); push(9'h073);
    check("R10 pre overrun", ovr_err, 1);
    port_en = 1'b0;
    @(negedge clk);
    check("R10 flag cleared", rx_flag, 0);
    check("R10 error cleared", ovr_err, 0);
    check("R10 ready low", in_ready, 0);
    port_en = 1'b1;
    cont_en = 1'b0;
    push(9'h0C4);
    check("R10 fresh after enable", dout_lo, 8'hC4);
    rd();
    check("R10 single entry", rx_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single_ovr();
    t_cont_ovr();
    t_simul();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule